// File: doc/BRIEF.md
# Big-endian load data formatter

This block sits between a word-wide data memory and the register write-back stage of a 32-bit core whose memory is byte-addressed. For each load it receives the effective address, a size code, a flag choosing zero padding instead of sign extension, and the aligned 32-bit memory word that holds the addressed bytes. It picks the addressed byte or halfword using big-endian lane order, where the lowest address sits in the most significant lane. It then widens the value to 32 bits and presents it with a register write enable.

An access whose address is not a multiple of its size, or whose size code is the reserved one, returns no data. It raises an address-error flag, drops the write enable and reports the faulting address instead. Loads travel on a valid/ready stream. A transfer happens on a rising clock edge where both valid and ready are high. While the output stream is stalled, the presented result stays unchanged.

A parameter picks one of two shapes. The registered shape adds one output stage, with a skid-free ready of `in_ready = !out_valid || out_ready`. The combinational shape passes valid forward and ready backward with no delay.

Top module: `ldfmt_top`

## Requirements
- R1: A byte load at address offset k (k = address bits 1:0) takes memory word bits [31-8k : 24-8k]; offset 0 is bits 31:24 and offset 3 is bits 7:0. The selected byte appears in `out_data` bits 7:0.
- R2: Size code 2'b00 is a byte load. With `in_unsigned`=0, bits 31:8 are copies of the byte's bit 7, so 0x80 gives 0xFFFFFF80 and 0xFF gives 0xFFFFFFFF. With `in_unsigned`=1, bits 31:8 are zero, so 0x80 gives 0x00000080.
- R3: Size code 2'b01 is a halfword load. Offset 0 takes word bits 31:16 and offset 2 takes bits 15:0. The value is sign-extended when `in_unsigned`=0 and zero-padded when it is 1.
- R4: Size code 2'b10 is a word load. At offset 0 it returns the memory word unchanged; bytes 0x11, 0x22, 0x33, 0x44 in ascending address order give 0x11223344.
- R5: A word load is misaligned unless address bits 1:0 are 00. A halfword load is misaligned when address bit 0 is 1. A byte load is never misaligned. Size code 2'b11 is always treated as an error.
- R6: For an erroneous access, the result has `out_exc`=1, `out_wen`=0, `out_data`=0 and `out_badaddr` equal to the load's address. Any other valid result has `out_exc`=0, `out_wen`=1 and `out_badaddr`=0.
- R7: While `out_valid` is 0, both `out_wen` and `out_exc` are 0.
- R8: With OUT_REG=1, an accepted load's result appears on the output one clock edge later. `in_ready` is high when the stage is empty or `out_ready` is high. A stalled result holds its data, exception flag and address unchanged. Results leave in acceptance order, and none is lost or duplicated.
- R9: With OUT_REG=0, the result is combinational from the inputs, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R10: During reset the registered shape presents `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load request is present |
| in_ready | output | 1 | The block accepts the request on this edge |
| in_addr | input | ADDR_W | Effective byte address of the load |
| in_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| in_unsigned | input | 1 | 1 zero-pads, 0 sign-extends |
| in_word | input | 32 | Aligned memory word holding the addressed bytes |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Downstream takes the result on this edge |
| out_data | output | 32 | Formatted load value, zero on error |
| out_wen | output | 1 | Register write enable |
| out_exc | output | 1 | Address-error exception |
| out_badaddr | output | ADDR_W | Faulting address, zero when no error |

## Verification
In the combinational shape, every result is due in the same cycle as its request. The bench compares it one time step after driving the inputs, well before the next edge. In the registered shape, a result is due one edge after the request is accepted. The bench records each accepted request's model result in a queue at the moment of the handshake. It pops and compares that result only in a cycle where `out_valid` and `out_ready` are both high, so random back-pressure cannot shift which result is expected. Stalled cycles are checked separately: outputs must not change until the result is taken.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int HALVES  = WORD_W / HALF_W;
  localparam int OFS_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/ldfmt_align_chk.sv
module ldfmt_align_chk
  import ldfmt_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] ofs,
  output logic             bad
);
  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = ofs[0];
      SZ_WORD: bad = |ofs;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ldfmt_lane_sel.sv
module ldfmt_lane_sel
  import ldfmt_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  output logic [BYTE_W-1:0] byte_val,
  output logic [HALF_W-1:0] half_val
);
  logic [BYTE_W-1:0] lane [LANES];
  logic [HALF_W-1:0] hlane [HALVES];

  // Lowest address occupies the most significant lane.
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign lane[k] = word[WORD_W-1-BYTE_W*k -: BYTE_W];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign hlane[j] = word[WORD_W-1-HALF_W*j -: HALF_W];
  end

  assign byte_val = lane[ofs];
  assign half_val = hlane[ofs[OFS_W-1]];
endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              zpad,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [HALF_W-1:0] half_val,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] value
);
  logic bfill;
  logic hfill;

  assign bfill = ~zpad & byte_val[BYTE_W-1];
  assign hfill = ~zpad & half_val[HALF_W-1];

  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE: value = {{(WORD_W-BYTE_W){bfill}}, byte_val};
      SZ_HALF: value = {{(WORD_W-HALF_W){hfill}}, half_val};
      SZ_WORD: value = word;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_size,
  input  logic              in_unsigned,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_wen,
  output logic              out_exc,
  output logic [ADDR_W-1:0] out_badaddr
);
  logic              misal;
  logic [BYTE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;
  logic [WORD_W-1:0] wide;

  logic [WORD_W-1:0] r_data;
  logic              r_wen;
  logic              r_exc;
  logic [ADDR_W-1:0] r_bad;

  ldfmt_align_chk u_align (
    .size (in_size),
    .ofs  (in_addr[OFS_W-1:0]),
    .bad  (misal)
  );

  ldfmt_lane_sel u_sel (
    .word     (in_word),
    .ofs      (in_addr[OFS_W-1:0]),
    .byte_val (sel_byte),
    .half_val (sel_half)
  );

  ldfmt_extend u_ext (
    .size     (in_size),
    .zpad     (in_unsigned),
    .byte_val (sel_byte),
    .half_val (sel_half),
    .word     (in_word),
    .value    (wide)
  );

  always_comb begin
    r_wen  = in_valid & ~misal;
    r_exc  = in_valid & misal;
    r_data = r_wen ? wide : '0;
    r_bad  = r_exc ? in_addr : '0;
  end

  if (OUT_REG) begin : g_reg
    logic              q_valid;
    logic [WORD_W-1:0] q_data;
    logic              q_wen;
    logic              q_exc;
    logic [ADDR_W-1:0] q_bad;

    assign in_ready = ~q_valid | out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_data  <= '0;
        q_wen   <= 1'b0;
        q_exc   <= 1'b0;
        q_bad   <= '0;
      end else if (in_ready) begin
        q_valid <= in_valid;
        q_data  <= r_data;
        q_wen   <= r_wen;
        q_exc   <= r_exc;
        q_bad   <= r_bad;
      end
    end

    assign out_valid   = q_valid;
    assign out_data    = q_data;
    assign out_wen     = q_wen;
    assign out_exc     = q_exc;
    assign out_badaddr = q_bad;
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_data    = r_data;
    assign out_wen     = r_wen;
    assign out_exc     = r_exc;
    assign out_badaddr = r_bad;
  end
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk
  import ldfmt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_size,
  input logic              in_unsigned,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_wen,
  input logic              out_exc,
  input logic [ADDR_W-1:0] out_badaddr
);
  // R7: idle output carries no write and no exception
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wen && !out_exc));

  // R6: an exception never writes and returns zero data
  assert_exc_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> (!out_wen && out_data == '0));

  // R6: a valid result either writes or faults, never both or neither
  assert_wen_xor_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wen != out_exc));

  if (OUT_REG) begin : g_reg_chk
    assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_exc) && $stable(out_badaddr)));

    assert_word_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'b10 && in_addr[1:0] == 2'b00)
        |=> (out_data == $past(in_word)));

    assert_rsvd_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_size == 2'b11)
        |=> (out_exc && out_badaddr == $past(in_addr)));
  end else begin : g_comb_chk
    assert_pass_flow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready == out_ready) && (out_valid == in_valid));
  end
endmodule

bind ldfmt_top ldfmt_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_ldfmt_top.sv
`timescale 1ns/1ps
module tb_ldfmt_top;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0]   data;
    logic          wen;
    logic          exc;
    logic [AW-1:0] bad;
  } res_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_size = '0;
  logic          in_unsigned = 1'b0;
  logic [31:0]   in_word = '0;
  logic          out_ready = 1'b0;

  logic          r_in_ready, r_out_valid, r_wen, r_exc;
  logic [31:0]   r_data;
  logic [AW-1:0] r_bad;
  logic          c_in_ready, c_out_valid, c_wen, c_exc;
  logic [31:0]   c_data;
  logic [AW-1:0] c_bad;

  int   n_checks = 0;
  int   n_errs   = 0;
  bit   finished = 1'b0;
  res_t exp_q [$];
  bit   stall_prev = 1'b0;
  res_t stall_snap;

  always #2.5 clk = ~clk;

  ldfmt_top #(.ADDR_W(AW), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_unsigned(in_unsigned), .in_word(in_word),
    .out_valid(r_out_valid), .out_ready(out_ready), .out_data(r_data),
    .out_wen(r_wen), .out_exc(r_exc), .out_badaddr(r_bad));

  ldfmt_top #(.ADDR_W(AW), .OUT_REG(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_unsigned(in_unsigned), .in_word(in_word),
    .out_valid(c_out_valid), .out_ready(1'b1), .out_data(c_data),
    .out_wen(c_wen), .out_exc(c_exc), .out_badaddr(c_bad));

  function automatic res_t model(logic [AW-1:0] a, logic [1:0] sz, logic zp, logic [31:0] w);
    res_t r;
    logic [1:0]  o = a[1:0];
    logic [7:0]  b = 8'(w >> (8 * (3 - int'(o))));
    logic [15:0] h = o[1] ? w[15:0] : w[31:16];
    bit bad = (sz == 2'b11) || (sz == 2'b10 && o != 2'b00) || (sz == 2'b01 && o[0]);
    r.wen = !bad;
    r.exc = bad;
    r.bad = bad ? a : '0;
    if (bad)              r.data = 32'h0;
    else if (sz == 2'b00) r.data = zp ? {24'h0, b} : {{24{b[7]}}, b};
    else if (sz == 2'b01) r.data = zp ? {16'h0, h} : {{16{h[15]}}, h};
    else                  r.data = w;
    return r;
  endfunction

  function automatic string data_tag(logic [1:0] sz);
    case (sz)
      2'b00:   return "R1 R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string pfx, logic [1:0] sz, res_t act, res_t exp);
    check(exp.exc ? "R6" : data_tag(sz), {pfx, " data"}, 64'(act.data), 64'(exp.data));
    check("R5", {pfx, " exc"}, 64'(act.exc), 64'(exp.exc));
    check("R6", {pfx, " wen"}, 64'(act.wen), 64'(exp.wen));
    check("R6", {pfx, " badaddr"}, 64'(act.bad), 64'(exp.bad));
  endtask

  // Drive one cycle of stimulus; returns whether the registered stage accepted it.
  task automatic step(logic v, logic [AW-1:0] a, logic [1:0] sz, logic zp,
                      logic [31:0] w, logic rdy, output bit took);
    res_t e, got;
    @(negedge clk);
    in_valid = v; in_addr = a; in_size = sz; in_unsigned = zp; in_word = w;
    out_ready = rdy;
    #1;
    // combinational shape: due now
    check("R9", "comb in_ready", 64'(c_in_ready), 64'(1));
    check("R9", "comb out_valid", 64'(c_out_valid), 64'(v));
    e = model(a, sz, zp, w);
    if (v) cmp("comb", sz, '{c_data, c_wen, c_exc, c_bad}, e);
    else begin
      check("R7", "comb idle wen", 64'(c_wen), 64'(0));
      check("R7", "comb idle exc", 64'(c_exc), 64'(0));
    end
    // registered shape
    got = '{r_data, r_wen, r_exc, r_bad};
    if (stall_prev) begin
      check("R8", "stall valid", 64'(r_out_valid), 64'(1));
      check("R8", "stall hold", 64'(got), 64'(stall_snap));
    end
    check("R8", "in_ready rule", 64'(r_in_ready), 64'(!r_out_valid || rdy));
    if (!r_out_valid) begin
      check("R7", "reg idle wen", 64'(r_wen), 64'(0));
      check("R7", "reg idle exc", 64'(r_exc), 64'(0));
    end
    took = v && r_in_ready;
    if (took) exp_q.push_back(e);
    if (r_out_valid && rdy) begin
      if (exp_q.size() < 2 && !(took && exp_q.size() == 1) && exp_q.size() == 0) begin
        check("R8", "unexpected result", 64'(1), 64'(0));
      end else begin
        res_t head = exp_q.pop_front();
        cmp("reg", 2'b11 - 2'b11 + (head.exc ? 2'b11 : 2'b00), got, head);
      end
    end
    stall_prev = r_out_valid && !rdy;
    stall_snap = got;
  endtask

  task automatic load(logic [AW-1:0] a, logic [1:0] sz, logic zp, logic [31:0] w);
    bit took;
    took = 1'b0;
    while (!took) step(1'b1, a, sz, zp, w, 1'b1, took);
  endtask

  initial begin
    bit took;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    #1;
    check("R10", "reset out_valid", 64'(r_out_valid), 64'(0));
    check("R10", "reset wen", 64'(r_wen), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // byte lanes, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      load(32'h1000 + k, 2'b00, 1'b0, 32'h127F80FF);
      load(32'h1000 + k, 2'b00, 1'b1, 32'h127F80FF);
    end
    // halfwords, aligned and not
    for (int k = 0; k < 4; k++) begin
      load(32'h2000 + k, 2'b01, 1'b0, 32'h80017FFE);
      load(32'h2000 + k, 2'b01, 1'b1, 32'h80017FFE);
    end
    // words, aligned and each misaligned offset
    for (int k = 0; k < 4; k++) load(32'h1004 + k, 2'b10, 1'b0, 32'h11223344);
    // reserved size code at an aligned address
    load(32'h3000, 2'b11, 1'b0, 32'hDEADBEEF);
    load(32'h3003, 2'b11, 1'b1, 32'hDEADBEEF);

    // random traffic with back-pressure
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), $urandom(), sz, 1'($urandom_range(0, 1)),
           $urandom(), ($urandom_range(0, 2) != 0), took);
    end
    // long stall then drain
    for (int i = 0; i < 4; i++) step(1'b0, '0, 2'b00, 1'b0, '0, 1'b0, took);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 2'b00, 1'b0, '0, 1'b1, took);
    check("R8", "all results delivered", 64'(exp_q.size()), 64'(0));

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule